// File: doc/BRIEF.md
# Guarded Power-Down Entry Controller

This block is the power-management controller of a small 8-bit microcontroller. It watches the special-function-register byte write bus. It stops the core clock only after a deliberate two-write sequence: an arm write to the power control register, then at once a start write to the same register. The start write is the last operation the core completes before its clock is gated. A stray or mistyped write therefore cannot freeze the chip.

A second register holds a wake enable and a wake-source select. While the block is powered down, it leaves that state in two ways. One is reset. The other is an enabled wake event from the selected source: a low level on the external interrupt pin, or a high level on a bus-activity input. Both inputs are asynchronous and pass through synchronisers clocked by the free-running clock, so they keep working while the core clock is gated. On wake, the clock gate opens, the power-down status drops, and the core sees a one-cycle wake pulse.

Top module: `pwrdn_ctl`

## Requirements
- R1: Reset (synchronous, active-low) clears the armed state, the wake enable, the source select, the spare control bits and the power-down status. After reset, `core_clk_en` is 1, `pd_active` is 0, `wake_pulse` is 0, and both registers read 0x00.
- R2: A write to the power control register (address `PCTL_ADDR`, default 0x87) with bit 1 (arm) set and bit 6 (start) clear, followed by a write to that register with bit 6 set and bit 1 clear as the next bus write, sets `pd_active` to 1 and `core_clk_en` to 0 from the clock edge that takes the start write. Idle cycles between the two writes are allowed. A repeated arm write keeps the block armed.
- R3: A write to the power control register with bits 1 and 6 both set never enters power-down. It also leaves the block unarmed.
- R4: Any other bus write between the arm write and the start write cancels the armed state, whatever its address. This includes writes to the second register and to unrelated addresses.
- R5: Reads of the power control register always return 0 in bits 1 and 6. Its other bits read back as last written.
- R6: The second power control register (address `PCTL2_ADDR`, default 0x88) keeps only bit 7 (wake enable) and bit 4 (source: 0 = external pin, 1 = bus activity). It reads back those two bits, with every other bit 0. Writing 0x80 selects pin wake and writing 0x90 selects bus wake.
- R7: While powered down with the wake enable at 0, neither wake input has any effect. Only reset leaves power-down.
- R8: With pin wake selected and enabled, a low level on `ext_wake_n` ends power-down at the third clock edge after it is applied (two synchroniser stages, then the state register). A high level on `bus_act` is ignored.
- R9: With bus wake selected and enabled, a high level on `bus_act` ends power-down with the same latency. A low level on `ext_wake_n` is ignored.
- R10: `wake_pulse` is high for exactly one cycle: the first cycle after power-down ends. It is never high at any other time.
- R11: If the selected wake condition already holds when power-down is entered (for example, the pin is low), `pd_active` stays high for exactly one cycle and then wakes.
- R12: Bus writes while powered down are ignored, and a start write without a preceding arm write has no effect.
- R13: Reset while powered down clears `pd_active` and reopens the clock gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock (never gated) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Read data (combinational) |
| ext_wake_n | input | 1 | Asynchronous external interrupt pin, active low |
| bus_act | input | 1 | Asynchronous bus-activity indication, active high |
| core_clk_en | output | 1 | Core clock enable, 0 while powered down |
| pd_active | output | 1 | Power-down status |
| wake_pulse | output | 1 | One-cycle wake indication to the core |

## Verification
Entry and wake can meet in neighbouring cycles. This happens when the selected wake condition is already present as the start write lands. The bench provokes it by holding the pin low before the arm/start pair, and requires power-down to last exactly one cycle, followed by a single wake pulse. A write can also coincide with the wake cycle. The bench checks that such a write changes no register and does not re-arm the block. All outputs are compared on every clock against a behavioural model in the bench.

// File: rtl/pd_pkg.sv
// Package: shared constants and types of the power-down controller.
// Assumes byte-wide register data (bit positions below must fit DATA_W).
package pd_pkg;

    // Bit positions in the power control register.
    localparam int ARM_BIT   = 1;
    localparam int START_BIT = 6;

    // Bit positions in the second power control register.
    localparam int WEN_BIT   = 7;
    localparam int SRC_BIT   = 4;

    // Wake source select encoding.
    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_BUS = 1'b1
    } wake_src_t;

    // Entry/exit sequencer states.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_DOWN  = 2'd2
    } pd_state_t;

endpackage

// File: rtl/pd_sync.sv
// Module: pd_sync
// Multi-stage synchroniser for an asynchronous level input.
// Assumes it is clocked by the free-running clock so it works while the
// core clock is gated. RESET_VAL is the inactive level of the input.
module pd_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pd_regs.sv
// Module: pd_regs
// Storage and read-back of the two power control registers.
// Assumes writes arrive already qualified (no writes while powered down).
// The arm and start flags are not stored here, so they always read 0.
module pd_regs
    import pd_pkg::*;
#(
    parameter int             ADDR_W     = 8,
    parameter int             DATA_W     = 8,
    parameter logic [ADDR_W-1:0] PCTL_ADDR  = 8'h87,
    parameter logic [ADDR_W-1:0] PCTL2_ADDR = 8'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wake_en,
    output wake_src_t         wake_src
);

    localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << ARM_BIT) | (DATA_W'(1) << START_BIT);

    logic [DATA_W-1:0] spare_q;
    logic              wen_q;
    wake_src_t         src_q;
    logic [DATA_W-1:0] pctl2_view;

    // Keep the plain bits of the power control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q <= '0;
        end else if (wr_ok && wr_addr == PCTL_ADDR) begin
            spare_q <= wr_data & ~FLAG_MASK;
        end
    end

    // Keep the wake enable and the wake source select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
            src_q <= SRC_PIN;
        end else if (wr_ok && wr_addr == PCTL2_ADDR) begin
            wen_q <= wr_data[WEN_BIT];
            src_q <= wake_src_t'(wr_data[SRC_BIT]);
        end
    end

    // Assemble the visible image of the second register.
    always_comb begin
        pctl2_view          = '0;
        pctl2_view[WEN_BIT] = wen_q;
        pctl2_view[SRC_BIT] = src_q;
    end

    // Select read data by address.
    always_comb begin
        if (rd_addr == PCTL_ADDR) begin
            rd_data = spare_q;
        end else if (rd_addr == PCTL2_ADDR) begin
            rd_data = pctl2_view;
        end else begin
            rd_data = '0;
        end
    end

    assign wake_en  = wen_q;
    assign wake_src = src_q;

endmodule

// File: rtl/pd_seq.sv
// Module: pd_seq
// Arm/start sequencer and wake exit. It enters power-down only on an arm
// write followed by a start write as the next bus write. It leaves on an
// enabled wake condition and then pulses wake for one cycle.
// Assumes the wake inputs are already synchronised.
module pd_seq
    import pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      pctl_hit,
    input  logic      arm_bit,
    input  logic      start_bit,
    input  logic      wake_en,
    input  wake_src_t wake_src,
    input  logic      ext_s_n,
    input  logic      bus_s,
    output logic      pd_active,
    output logic      wake_pulse
);

    pd_state_t state_q, state_d;
    logic      pulse_q, pulse_d;
    logic      arm_only, start_only, wake_req;

    // Classify the current write against the two flags.
    always_comb begin
        arm_only   = wr_en && pctl_hit && arm_bit && !start_bit;
        start_only = wr_en && pctl_hit && start_bit && !arm_bit;
    end

    // Decide whether the selected, enabled source requests wake.
    always_comb begin
        if (!wake_en) begin
            wake_req = 1'b0;
        end else if (wake_src == SRC_BUS) begin
            wake_req = bus_s;
        end else begin
            wake_req = !ext_s_n;
        end
    end

    // Next-state logic of the entry/exit sequencer.
    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (arm_only) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (start_only) begin
                    state_d = ST_DOWN;
                end else if (arm_only) begin
                    state_d = ST_ARMED;
                end else if (wr_en) begin
                    state_d = ST_RUN;
                end
            end
            ST_DOWN: begin
                if (wake_req) begin
                    state_d = ST_RUN;
                    pulse_d = 1'b1;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // State and wake pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
        end
    end

    assign pd_active  = (state_q == ST_DOWN);
    assign wake_pulse = pulse_q;

endmodule

// File: rtl/pwrdn_ctl.sv
// Module: pwrdn_ctl (top)
// Guarded power-down entry controller on a register write bus. It gates the
// core clock after an arm/start write pair and reopens it on reset or on
// an enabled wake event. Assumes clk is free-running and that wr_en is
// a one-cycle strobe per write.
module pwrdn_ctl
    import pd_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] PCTL_ADDR   = 8'h87,
    parameter logic [ADDR_W-1:0] PCTL2_ADDR  = 8'h88,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_wake_n,
    input  logic              bus_act,
    output logic              core_clk_en,
    output logic              pd_active,
    output logic              wake_pulse
);

    logic      ext_s_n, bus_s, wr_ok, pctl_hit, wake_en;
    wake_src_t wake_src;

    // Qualify the write bus: nothing is accepted while powered down.
    always_comb begin
        wr_ok    = wr_en && !pd_active;
        pctl_hit = (wr_addr == PCTL_ADDR);
    end

    pd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_pin (
        .clk(clk), .rst_n(rst_n), .d(ext_wake_n), .q(ext_s_n)
    );

    pd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_sync_bus (
        .clk(clk), .rst_n(rst_n), .d(bus_act), .q(bus_s)
    );

    pd_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PCTL_ADDR(PCTL_ADDR), .PCTL2_ADDR(PCTL2_ADDR)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wake_en(wake_en), .wake_src(wake_src)
    );

    pd_seq i_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok),
        .pctl_hit(pctl_hit),
        .arm_bit(wr_data[ARM_BIT]), .start_bit(wr_data[START_BIT]),
        .wake_en(wake_en), .wake_src(wake_src),
        .ext_s_n(ext_s_n), .bus_s(bus_s),
        .pd_active(pd_active), .wake_pulse(wake_pulse)
    );

    assign core_clk_en = !pd_active;

endmodule

// File: rtl/pwrdn_ctl_chk.sv
// Module: pwrdn_ctl_chk
// Property checker for pwrdn_ctl, attached by bind below.
module pwrdn_ctl_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] PCTL_ADDR  = 8'h87
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              core_clk_en,
    input logic              pd_active,
    input logic              wake_pulse,
    input logic              wake_en
);

    AST_ENTRY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> $past(wr_en && wr_addr == PCTL_ADDR && wr_data[6] && !wr_data[1])); // R2

    AST_GATE_CLOSED_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> !core_clk_en); // R2

    AST_BOTH_FLAGS_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_active && wr_en && wr_addr == PCTL_ADDR && wr_data[1] && wr_data[6]) |=> !pd_active); // R3

    AST_FLAGS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == PCTL_ADDR) |-> (!rd_data[1] && !rd_data[6])); // R5

    AST_NO_WAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && !wake_en) |=> pd_active); // R7

    AST_WAKE_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R10

    AST_WAKE_PULSE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $fell(pd_active)); // R10

endmodule

bind pwrdn_ctl pwrdn_ctl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PCTL_ADDR(PCTL_ADDR)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .core_clk_en(core_clk_en), .pd_active(pd_active),
    .wake_pulse(wake_pulse), .wake_en(wake_en)
);

// File: tb/test_pwrdn_ctl.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios with explicit checks.
module test_pwrdn_ctl;

    localparam int          SYNC = 2;
    localparam logic [7:0]  PA   = 8'h87;
    localparam logic [7:0]  PB   = 8'h88;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = PA;
    logic [7:0] rd_data;
    logic       ext_wake_n = 1'b1;
    logic       bus_act = 1'b0;
    logic       core_clk_en, pd_active, wake_pulse;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    pwrdn_ctl i_pwrdn_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_wake_n(ext_wake_n), .bus_act(bus_act),
        .core_clk_en(core_clk_en), .pd_active(pd_active), .wake_pulse(wake_pulse)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model state.
    bit   m_pd, m_arm, m_pulse, m_wen, m_src;
    int   m_spare;
    bit   ext_q[$];
    bit   bus_q[$];

    always @(posedge clk) begin
        bit ext_s, bus_s, wake;
        if (!rst_n) begin
            m_pd = 0; m_arm = 0; m_pulse = 0; m_wen = 0; m_src = 0; m_spare = 0;
            ext_q = {}; bus_q = {};
            for (int i = 0; i < SYNC; i++) begin
                ext_q.push_back(1'b1);
                bus_q.push_back(1'b0);
            end
        end else begin
            ext_s = ext_q[0];
            bus_s = bus_q[0];
            m_pulse = 0;
            if (m_pd) begin
                wake = m_wen && (m_src ? bus_s : !ext_s);
                if (wake) begin
                    m_pd = 0;
                    m_pulse = 1;
                end
            end else if (wr_en) begin
                if (wr_addr == PA) begin
                    if (m_arm && wr_data[6] && !wr_data[1]) begin
                        m_pd = 1;
                        m_arm = 0;
                    end else begin
                        m_arm = wr_data[1] && !wr_data[6];
                    end
                    m_spare = wr_data & 8'hBD;
                end else if (wr_addr == PB) begin
                    m_wen = wr_data[7];
                    m_src = wr_data[4];
                    m_arm = 0;
                end else begin
                    m_arm = 0;
                end
            end
            void'(ext_q.pop_front());
            ext_q.push_back(ext_wake_n);
            void'(bus_q.pop_front());
            bus_q.push_back(bus_act);
        end
        #3;
        chk(cur_req, "model pd_active", int'(pd_active), int'(m_pd));
        chk(cur_req, "model core_clk_en", int'(core_clk_en), int'(!m_pd));
        chk(cur_req, "model wake_pulse", int'(wake_pulse), int'(m_pulse));
        if (rd_addr == PA)
            chk(cur_req, "model rd_data", int'(rd_data), m_spare);
        else if (rd_addr == PB)
            chk(cur_req, "model rd_data", int'(rd_data), (int'(m_wen) << 7) | (int'(m_src) << 4));
        else
            chk(cur_req, "model rd_data", int'(rd_data), 0);
    end

    // Write for exactly one edge; starts and ends on a falling edge.
    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL WATCHDOG: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        do_reset();
        chk("R1", "pd_active", int'(pd_active), 0);
        chk("R1", "core_clk_en", int'(core_clk_en), 1);
        chk("R1", "wake_pulse", int'(wake_pulse), 0);
        rd_addr = PB; #1;
        chk("R1", "rd PCTL2", int'(rd_data), 0);
        rd_addr = PA; #1;
        chk("R1", "rd PCTL", int'(rd_data), 0);

        // R5: flag bits read zero, others stored
        cur_req = "R5";
        wr(PA, 8'hFF);
        #1 chk("R5", "rd after 0xFF", int'(rd_data), 8'hBD);
        chk("R3", "no entry on both flags", int'(pd_active), 0);
        wr(PA, 8'h00);

        // R6: second register stores bits 7 and 4 only
        cur_req = "R6";
        rd_addr = PB;
        wr(PB, 8'hFF);
        #1 chk("R6", "rd after 0xFF", int'(rd_data), 8'h90);
        wr(PB, 8'h80);
        #1 chk("R6", "rd after 0x80", int'(rd_data), 8'h80);
        rd_addr = PA;

        // R4: intervening writes cancel
        cur_req = "R4";
        wr(PA, 8'h02); wr(PB, 8'h80); wr(PA, 8'h40);
        idle(2);
        chk("R4", "cancel by PCTL2 write", int'(pd_active), 0);
        wr(PA, 8'h02); wr(8'h10, 8'h55); wr(PA, 8'h40);
        idle(2);
        chk("R4", "cancel by other address", int'(pd_active), 0);

        // R3: both flags cancel arming
        cur_req = "R3";
        wr(PA, 8'h02); wr(PA, 8'h42); wr(PA, 8'h40);
        idle(2);
        chk("R3", "both flags then start", int'(pd_active), 0);

        // R12: start without arm
        cur_req = "R12";
        wr(PA, 8'h40);
        idle(2);
        chk("R12", "start alone", int'(pd_active), 0);

        // R2: arm, idle, arm again, start
        cur_req = "R2";
        wr(PA, 8'h02); idle(3); wr(PA, 8'h02); wr(PA, 8'h40);
        chk("R2", "pd after start", int'(pd_active), 1);
        chk("R2", "gate closed", int'(core_clk_en), 0);

        // R8: pin wake, bus ignored
        cur_req = "R8";
        bus_act = 1'b1; idle(6);
        chk("R8", "bus ignored under pin select", int'(pd_active), 1);
        bus_act = 1'b0; idle(3);
        ext_wake_n = 1'b0;
        idle(2);
        chk("R8", "still down after 2 edges", int'(pd_active), 1);
        idle(1);
        chk("R8", "awake after 3 edges", int'(pd_active), 0);
        chk("R10", "pulse on wake cycle", int'(wake_pulse), 1);
        idle(1);
        chk("R10", "pulse one cycle", int'(wake_pulse), 0);
        ext_wake_n = 1'b1; idle(3);

        // R9: bus wake, pin ignored
        cur_req = "R9";
        wr(PB, 8'h90); wr(PA, 8'h02); wr(PA, 8'h40);
        ext_wake_n = 1'b0; idle(6);
        chk("R9", "pin ignored under bus select", int'(pd_active), 1);
        ext_wake_n = 1'b1; idle(3);
        bus_act = 1'b1; idle(3);
        chk("R9", "bus wake", int'(pd_active), 0);
        bus_act = 1'b0; idle(3);

        // R7 / R12: wake disabled, writes while down ignored
        cur_req = "R7";
        wr(PB, 8'h00); wr(PA, 8'h02); wr(PA, 8'h40);
        ext_wake_n = 1'b0; bus_act = 1'b1;
        idle(8);
        chk("R7", "no wake when disabled", int'(pd_active), 1);
        cur_req = "R12";
        wr(PB, 8'h80);
        rd_addr = PB; #1;
        chk("R12", "write while down ignored", int'(rd_data), 0);
        idle(4);
        chk("R12", "still down", int'(pd_active), 1);
        rd_addr = PA;

        // R13: reset exits power-down
        cur_req = "R13";
        do_reset();
        chk("R13", "pd cleared by reset", int'(pd_active), 0);
        chk("R13", "gate open after reset", int'(core_clk_en), 1);
        bus_act = 1'b0; idle(3);

        // R11: pin already low at entry, plus a write in the wake cycle
        cur_req = "R11";
        wr(PB, 8'h80); idle(3);
        wr(PA, 8'h02); wr(PA, 8'h40);
        chk("R11", "entered", int'(pd_active), 1);
        wr(PA, 8'h02);
        chk("R11", "one-cycle stay", int'(pd_active), 0);
        chk("R10", "pulse after short stay", int'(wake_pulse), 1);
        wr(PA, 8'h40);
        idle(2);
        chk("R12", "write in wake cycle did not arm", int'(pd_active), 0);
        ext_wake_n = 1'b1; idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule